// File: doc/BRIEF.md
# Bit-masked PHY control register bank

This block holds a small set of 32-bit control registers. Every write word carries its own per-bit write enable: bits 31:16 select which of bits 15:0 are updated, and all other stored bits keep their value. Software can therefore change one field, or pulse one bit, without reading the register first.

The configuration register drives a PHY configuration port. Its outputs are a 6-bit target address, a 4-bit data value and a write strobe, all taken directly from the stored bits. The lane control register holds one idle control for each of four lanes. A read-only status word shows the live PLL lock flag and the live PLL output flag. The register bus has a word index, write data, a single-cycle write strobe and a combinational read-data path.

Word index map: 0 is the configuration register, 1 is the lane control register, 2 is the status word, and 3 is unmapped.

Top module: `cfg_mask_bank`

## Requirements
- R1: After rst_ni is asserted low, every stored bit is 0. All of cfg_addr_o, cfg_data_o, cfg_wr_o and lane_idle_o read 0.
- R2: On a write (we_i high at a rising clock edge) to index 0 or 1, stored bit x takes wdata_i[x] when wdata_i[x+16] is 1, and otherwise keeps its value.
- R3: cfg_data_o equals bits 10:7 of the configuration register, and cfg_addr_o equals bits 6:1 of the same register.
- R4: cfg_wr_o equals bit 0 of the configuration register, so it can be raised and lowered without disturbing the address and data fields.
- R5: lane_idle_o[n] equals bit 3+n of the lane control register, for n from 0 to 3. A 1 places lane n in idle.
- R6: A read of index 2 returns pll_locked_i on bit 9 and pll_out_i on bit 10, with every other bit 0.
- R7: A write to index 2 changes no stored bit and no output.
- R8: Bits 31:16 of rdata_o always read 0. For index 0 and 1, bits 15:0 return the stored value.
- R9: A read of index 3 returns 0. A write to index 3 changes no stored bit.
- R10: A write whose upper half is 0, or a cycle without we_i, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write word: enable mask in 31:16, value in 15:0 |
| we_i | input | 1 | Single-cycle write strobe |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pll_locked_i | input | 1 | PLL lock flag |
| pll_out_i | input | 1 | PLL output flag |
| cfg_addr_o | output | 6 | PHY configuration address |
| cfg_data_o | output | 4 | PHY configuration data |
| cfg_wr_o | output | 1 | PHY configuration write strobe |
| lane_idle_o | output | 4 | Per-lane idle controls |

## Verification
A stored bit that is wrong appears at the field outputs on the clock edge that stores it. The same bit appears on rdata_o as soon as its index is selected. The bench therefore checks the field outputs and the readback in the cycle right after each write. Partial masks, empty masks, writes to the status word and writes to the unmapped index each get a directed case, because a mask or decode fault shows up only as a neighbouring bit that changes.

// File: rtl/cfg_mask_pkg.sv
package cfg_mask_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int IDX_W  = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_CFG    = 2'd0,
    IDX_LANE   = 2'd1,
    IDX_STATUS = 2'd2,
    IDX_NONE   = 2'd3
  } reg_idx_e;

  // configuration register field layout (decoded by the PHY)
  localparam int CFG_WR_BIT    = 0;
  localparam int CFG_ADDR_LSB  = 1;
  localparam int CFG_ADDR_W    = 6;
  localparam int CFG_DATA_LSB  = 7;
  localparam int CFG_DATA_W    = 4;
  // status word layout
  localparam int STS_LOCK_BIT  = 9;
  localparam int STS_OUT_BIT   = 10;
  // per-lane status words on the config port
  localparam logic [CFG_ADDR_W-1:0] LANE_STS_BASE = 6'h30;
endpackage

// File: rtl/cfg_masked_reg.sv
module cfg_masked_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] wmask_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[b] <= 1'b0;
      else if (wr_i && wmask_i[b])  q_o[b] <= wdata_i[b];
    end
  end

  assert_unmasked_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(q_o)) & ~$past(wmask_i)) == '0);
  assert_masked_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(wdata_i)) & $past(wmask_i)) == '0);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfg_mask_pkg::*;
(
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [HALF_W-1:0] cfg_q_i,
  input  logic [HALF_W-1:0] lane_q_i,
  input  logic              pll_locked_i,
  input  logic              pll_out_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [HALF_W-1:0] sts_w;
  logic [HALF_W-1:0] low_w;

  always_comb begin
    sts_w               = '0;
    sts_w[STS_LOCK_BIT] = pll_locked_i;
    sts_w[STS_OUT_BIT]  = pll_out_i;
    case (reg_idx_e'(addr_i))
      IDX_CFG:    low_w = cfg_q_i;
      IDX_LANE:   low_w = lane_q_i;
      IDX_STATUS: low_w = sts_w;
      default:    low_w = '0;
    endcase
    rdata_o = {{HALF_W{1'b0}}, low_w};
  end
endmodule

// File: rtl/cfg_mask_bank.sv
module cfg_mask_bank
  import cfg_mask_pkg::*;
#(
  parameter int NUM_LANES     = 4,
  parameter int LANE_IDLE_LSB = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic                  we_i,
  output logic [WORD_W-1:0]     rdata_o,
  input  logic                  pll_locked_i,
  input  logic                  pll_out_i,
  output logic [CFG_ADDR_W-1:0] cfg_addr_o,
  output logic [CFG_DATA_W-1:0] cfg_data_o,
  output logic                  cfg_wr_o,
  output logic [NUM_LANES-1:0]  lane_idle_o
);
  localparam int NUM_WR = 2;

  logic [HALF_W-1:0] reg_q [NUM_WR];
  logic [HALF_W-1:0] wmask, wval;

  assign wmask = wdata_i[WORD_W-1:HALF_W];
  assign wval  = wdata_i[HALF_W-1:0];

  for (genvar r = 0; r < NUM_WR; r++) begin : g_reg
    logic sel;
    assign sel = we_i && (addr_i == IDX_W'(r));
    cfg_masked_reg #(.W(HALF_W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (sel),
      .wdata_i (wval),
      .wmask_i (wmask),
      .q_o     (reg_q[r])
    );
  end

  assign cfg_wr_o    = reg_q[IDX_CFG][CFG_WR_BIT];
  assign cfg_addr_o  = reg_q[IDX_CFG][CFG_ADDR_LSB +: CFG_ADDR_W];
  assign cfg_data_o  = reg_q[IDX_CFG][CFG_DATA_LSB +: CFG_DATA_W];
  assign lane_idle_o = reg_q[IDX_LANE][LANE_IDLE_LSB +: NUM_LANES];

  cfg_readback u_rd (
    .addr_i       (addr_i),
    .cfg_q_i      (reg_q[IDX_CFG]),
    .lane_q_i     (reg_q[IDX_LANE]),
    .pll_locked_i (pll_locked_i),
    .pll_out_i    (pll_out_i),
    .rdata_o      (rdata_o)
  );

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[WORD_W-1:HALF_W] == '0);
  assert_cfg_fields_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_CFG) |-> (rdata_o[CFG_ADDR_LSB +: CFG_ADDR_W] == cfg_addr_o &&
                             rdata_o[CFG_DATA_LSB +: CFG_DATA_W] == cfg_data_o));
  assert_cfg_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_CFG) |-> rdata_o[CFG_WR_BIT] == cfg_wr_o);
  assert_lane_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_LANE) |-> rdata_o[LANE_IDLE_LSB +: NUM_LANES] == lane_idle_o);
  assert_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_STATUS) |-> (rdata_o[STS_LOCK_BIT] == pll_locked_i &&
                                rdata_o[STS_OUT_BIT] == pll_out_i &&
                                $countones(rdata_o) == 32'(pll_locked_i) + 32'(pll_out_i)));
  assert_status_ro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == IDX_STATUS) |=> ($stable(cfg_addr_o) && $stable(cfg_data_o) &&
                                        $stable(cfg_wr_o) && $stable(lane_idle_o)));
  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_NONE) |-> rdata_o == '0);
endmodule

// File: tb/sim_cfg_mask_bank.sv
module sim_cfg_mask_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        lock = 1'b0, pout = 1'b0;
  logic [5:0]  c_addr;
  logic [3:0]  c_data;
  logic        c_wr;
  logic [3:0]  idle;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_cfg = '0, m_lane = '0;

  always #4 clk = ~clk;

  cfg_mask_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pll_locked_i(lock), .pll_out_i(pout),
    .cfg_addr_o(c_addr), .cfg_data_o(c_data), .cfg_wr_o(c_wr), .lane_idle_o(idle)
  );

  function automatic logic [15:0] upd(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    if (a == 2'd0) m_cfg = upd(m_cfg, d);
    if (a == 2'd1) m_lane = upd(m_lane, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic chk_outs(input string req);
    chk({req, " R3 addr"}, 32'(c_addr), 32'(m_cfg[6:1]));
    chk({req, " R3 data"}, 32'(c_data), 32'(m_cfg[10:7]));
    chk({req, " R4 strobe"}, 32'(c_wr), 32'(m_cfg[0]));
    chk({req, " R5 idle"}, 32'(idle), 32'(m_lane[6:3]));
    rd({req, " R8 cfg rb"}, 2'd0, {16'h0, m_cfg});
    rd({req, " R8 lane rb"}, 2'd1, {16'h0, m_lane});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 outputs", {c_addr, c_data, c_wr, idle}, '0);
    rd("R1 cfg", 2'd0, '0);
    rd("R1 lane", 2'd1, '0);
    rd("R1 status", 2'd2, '0);
  endtask

  task automatic t_cfg_fields;
    wr(2'd0, 32'h07FE_0560);   // data A at 10:7, addr 0x30 at 6:1
    chk("R3 addr 0x30", 32'(c_addr), 32'h30);
    chk("R3 data 0xA", 32'(c_data), 32'hA);
    chk_outs("R2 cfg");
  endtask

  task automatic t_strobe;
    wr(2'd0, 32'h0001_0001);
    chk("R4 strobe high", 32'(c_wr), 32'h1);
    chk_outs("R4 pulse on");
    wr(2'd0, 32'h0001_0000);
    chk("R4 strobe low", 32'(c_wr), 32'h0);
    chk_outs("R4 pulse off");
  endtask

  task automatic t_partial;
    wr(2'd0, 32'h0780_FFFF);
    chk("R2 partial data", 32'(c_data), 32'hF);
    chk("R2 partial addr kept", 32'(c_addr), 32'h30);
    chk_outs("R2 partial");
  endtask

  task automatic t_zero_mask;
    logic [15:0] c0 = m_cfg;
    wr(2'd0, 32'h0000_FFFF);
    wr(2'd1, 32'h0000_FFFF);
    rd("R10 cfg unchanged", 2'd0, {16'h0, c0});
    chk_outs("R10 zero mask");
  endtask

  task automatic t_lanes;
    wr(2'd1, 32'h0020_0020);
    chk("R5 lane C idle", 32'(idle), 32'b0100);
    wr(2'd1, 32'h0078_0078);
    chk("R5 all idle", 32'(idle), 32'b1111);
    wr(2'd1, 32'h0008_0000);
    chk("R5 lane A active", 32'(idle), 32'b1110);
    chk_outs("R5 lanes");
  endtask

  task automatic t_status;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lock = i[0]; pout = i[1];
      rd("R6 status", 2'd2, {21'h0, pout, lock, 9'h0});
    end
  endtask

  task automatic t_status_ro;
    wr(2'd2, 32'hFFFF_FFFF);
    lock = 1'b0; pout = 1'b1;
    rd("R7 status after write", 2'd2, 32'h0000_0400);
    chk_outs("R7 write to status");
  endtask

  task automatic t_unmapped;
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R9 unmapped read", 2'd3, '0);
    chk_outs("R9 write to unmapped");
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_fields();
    t_strobe();
    t_partial();
    t_zero_mask();
    t_lanes();
    t_status();
    t_status_ro();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule